// File: doc/BRIEF.md
# Frame Capture Sequencer

This block controls the capture of one frame from a pixel pipeline into memory. Software uses a small register bus to program a destination address, a line pitch and a packed frame size. It then writes a start bit in the control word. The block raises a one-cycle start strobe toward the memory writer and reports busy. It counts the line-done strobes that the writer returns, and it ends the frame once the count reaches the programmed height.

Software may cut a frame short with an abort bit. The block then drops busy at once and sends a one-cycle abort strobe to the writer. An optional interrupt is raised whenever the block goes from busy to idle, and it stays up until software clears the interrupt-enable bit. A second option issues an extra vertical-start pulse when a frame ends normally. A power-down bit drives a level output straight to the internal memory. The block does not model pixel packing, tiling, rotation or the bus master itself.

Top module: `fwb_ctrl`

## Requirements
- R1: After reset the pointer, pitch, size and progress registers read 0. The control word reads 0x5440_0000, and irq, mem_pd, wr_start, wr_abort and vstart are all 0.
- R2: Byte offsets are 0x00 pointer, 0x04 pitch, 0x08 size and 0x10 progress. Pointer and pitch read back exactly what was written. In the size word, bits 31:16 hold the height and bits 15:0 hold the width.
- R3: Control bits 31:24 always read 0x54 and bits 23:22 always read 01. Bit 0 (start) and bit 14 (abort) always read 0. Bit 1 reads busy. Bits 21:15 and 13:2 read back the last value written.
- R4: A control write with bit 0 set and bit 14 clear, made while idle, is accepted. From the next cycle busy reads 1 and progress reads 0, and wr_start is high for exactly that one cycle.
- R5: Each cycle with line_done high while busy adds one to progress. line_done while idle leaves progress unchanged.
- R6: Once busy and progress is at least the programmed height, busy reads 0 one cycle later and progress keeps its value. A height of 0 ends the frame one cycle after the start.
- R7: A start request written while busy is ignored: it gives no wr_start pulse and no vstart pulse, and progress is not changed.
- R8: A control write with bit 14 set, made while busy, drops busy at that edge and pulses wr_abort for one cycle. Progress is held and no vstart pulse is issued. An abort written while idle gives no wr_abort pulse.
- R9: If bit 2 is set, irq rises at the same edge where busy falls, whether the frame completed or was aborted. irq then stays high until a control write with bit 2 clear. With bit 2 clear, irq stays 0.
- R10: vstart pulses for one cycle with each accepted start. If bit 15 is set, vstart also pulses at the edge where a frame completes normally.
- R11: The mem_pd output follows control bit 21.
- R12: Writes to the progress register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational by default) |
| line_done | input | 1 | Writer has committed one line |
| wr_start | output | 1 | One-cycle frame start to the writer |
| wr_abort | output | 1 | One-cycle frame abort to the writer |
| vstart | output | 1 | One-cycle vertical start request to the pipeline |
| mem_pd | output | 1 | Power-down level for the internal memory |
| irq | output | 1 | Idle interrupt, level |

## Verification
The assertions assume that line_done arrives as single-cycle strobes. They also assume that a register access lasts one cycle, with bus_sel high and the address held for that cycle. The bench only drives the bus through one-cycle write and read tasks. It pulses line_done one cycle at a time. It leaves the height unchanged while a frame is running, so the progress count never overshoots the limit it is compared against.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
   localparam int OFS_PTR   = 'h00;
   localparam int OFS_PITCH = 'h04;
   localparam int OFS_SIZE  = 'h08;
   localparam int OFS_CTRL  = 'h0C;
   localparam int OFS_PROG  = 'h10;

   localparam int B_GO    = 0;
   localparam int B_BUSY  = 1;
   localparam int B_IE    = 2;
   localparam int B_ABORT = 14;
   localparam int B_REEOF = 15;
   localparam int B_PD    = 21;

   localparam logic [7:0]  TAG_HI  = 8'h54;
   localparam logic [1:0]  TAG_REV = 2'b01;
   localparam logic [31:0] CTRL_RW_MASK = 32'h003F_BFFC;
   localparam logic [31:0] CTRL_FIXED   = {TAG_HI, TAG_REV, 22'd0};

   typedef struct packed {
      logic ctrl_wr;
      logic start_req;
      logic abort_req;
      logic ie_val;
   } ctrl_cmd_t;
endpackage

// File: rtl/fwb_regs.sv
module fwb_regs
   import fwb_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int SIZE_W   = 16,
   parameter int READ_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              busy,
   input  logic [SIZE_W-1:0] progress,
   output logic [SIZE_W-1:0] height,
   output logic              ie,
   output logic              reeof,
   output logic              pwr_dn,
   output ctrl_cmd_t         cmd
);
   logic [31:0]       ptr_q, pitch_q, cfg_q;
   logic [SIZE_W-1:0] height_q, width_q;
   logic              wr_any;
   logic              hit_ptr, hit_pitch, hit_size, hit_ctrl, hit_prog;
   logic [31:0]       rd_mux;

   if (SIZE_W < 1 || SIZE_W > 16) begin : g_bad_size
      $error("fwb_regs: SIZE_W must lie in 1..16");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("fwb_regs: ADDR_W must be at least 5");
   end

   assign hit_ptr   = (bus_addr == ADDR_W'(OFS_PTR));
   assign hit_pitch = (bus_addr == ADDR_W'(OFS_PITCH));
   assign hit_size  = (bus_addr == ADDR_W'(OFS_SIZE));
   assign hit_ctrl  = (bus_addr == ADDR_W'(OFS_CTRL));
   assign hit_prog  = (bus_addr == ADDR_W'(OFS_PROG));
   assign wr_any    = bus_sel & bus_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q    <= '0;
         pitch_q  <= '0;
         height_q <= '0;
         width_q  <= '0;
         cfg_q    <= '0;
      end else if (wr_any) begin
         if (hit_ptr)   ptr_q   <= bus_wdata;
         if (hit_pitch) pitch_q <= bus_wdata;
         if (hit_size) begin
            width_q  <= bus_wdata[SIZE_W-1:0];
            height_q <= bus_wdata[16 +: SIZE_W];
         end
         if (hit_ctrl)  cfg_q   <= bus_wdata & CTRL_RW_MASK;
      end
   end

   always_comb begin
      cmd.ctrl_wr   = wr_any & hit_ctrl;
      cmd.start_req = wr_any & hit_ctrl & bus_wdata[B_GO];
      cmd.abort_req = wr_any & hit_ctrl & bus_wdata[B_ABORT];
      cmd.ie_val    = bus_wdata[B_IE];
   end

   assign height = height_q;
   assign ie     = cfg_q[B_IE];
   assign reeof  = cfg_q[B_REEOF];
   assign pwr_dn = cfg_q[B_PD];

   always_comb begin
      rd_mux = '0;
      if (hit_ptr)   rd_mux = ptr_q;
      if (hit_pitch) rd_mux = pitch_q;
      if (hit_size)  rd_mux = {16'(height_q), 16'(width_q)};
      if (hit_ctrl)  rd_mux = CTRL_FIXED | cfg_q | (32'(busy) << B_BUSY);
      if (hit_prog)  rd_mux = 32'(progress);
   end

   if (READ_REG != 0) begin : g_rd_flop
      logic [31:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  rd_q <= '0;
         else if (bus_sel && !bus_wr) rd_q <= rd_mux;
      end
      assign bus_rdata = rd_q;
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end
endmodule

// File: rtl/fwb_seq.sv
module fwb_seq
   import fwb_pkg::*;
#(
   parameter int SIZE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  ctrl_cmd_t         cmd,
   input  logic [SIZE_W-1:0] height,
   input  logic              reeof,
   input  logic              line_done,
   output logic              busy,
   output logic [SIZE_W-1:0] progress,
   output logic              wr_start,
   output logic              wr_abort,
   output logic              vstart,
   output logic              idle_evt
);
   logic              busy_q, start_ok, abort_ok, done_now, step;
   logic [SIZE_W-1:0] prog_q;
   logic              start_q, abort_q, vs_q;

   assign start_ok = cmd.start_req & ~cmd.abort_req & ~busy_q;
   assign abort_ok = cmd.abort_req & busy_q;
   assign done_now = busy_q & (prog_q >= height);
   assign step     = busy_q & line_done & ~done_now & ~abort_ok;
   assign idle_evt = abort_ok | done_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         prog_q  <= '0;
         start_q <= 1'b0;
         abort_q <= 1'b0;
         vs_q    <= 1'b0;
      end else begin
         start_q <= start_ok;
         abort_q <= abort_ok;
         vs_q    <= start_ok | (done_now & ~abort_ok & reeof);
         if (start_ok) begin
            busy_q <= 1'b1;
            prog_q <= '0;
         end else begin
            if (idle_evt) busy_q <= 1'b0;
            if (step)     prog_q <= prog_q + 1'b1;
         end
      end
   end

   assign busy     = busy_q;
   assign progress = prog_q;
   assign wr_start = start_q;
   assign wr_abort = abort_q;
   assign vstart   = vs_q;
endmodule

// File: rtl/fwb_irq.sv
module fwb_irq
   import fwb_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      idle_evt,
   input  logic      ie,
   input  ctrl_cmd_t cmd,
   output logic      irq
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         pend_q <= 1'b0;
      else if (cmd.ctrl_wr && !cmd.ie_val) pend_q <= 1'b0;
      else if (idle_evt && ie)             pend_q <= 1'b1;
   end

   assign irq = pend_q;
endmodule

// File: rtl/fwb_ctrl.sv
module fwb_ctrl
   import fwb_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int SIZE_W   = 16,
   parameter int READ_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              line_done,
   output logic              wr_start,
   output logic              wr_abort,
   output logic              vstart,
   output logic              mem_pd,
   output logic              irq
);
   ctrl_cmd_t         cmd;
   logic              busy, ie, reeof, idle_evt;
   logic [SIZE_W-1:0] progress, height;

   fwb_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .READ_REG(READ_REG)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .progress(progress), .height(height), .ie(ie),
      .reeof(reeof), .pwr_dn(mem_pd), .cmd(cmd)
   );

   fwb_seq #(.SIZE_W(SIZE_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .height(height), .reeof(reeof),
      .line_done(line_done), .busy(busy), .progress(progress),
      .wr_start(wr_start), .wr_abort(wr_abort), .vstart(vstart),
      .idle_evt(idle_evt)
   );

   fwb_irq u_irq (
      .clk(clk), .rst_n(rst_n), .idle_evt(idle_evt), .ie(ie), .cmd(cmd),
      .irq(irq)
   );
endmodule

// File: rtl/fwb_chk.sv
module fwb_chk
   import fwb_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int SIZE_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              wr_start,
   input logic              wr_abort,
   input logic              vstart,
   input logic              mem_pd,
   input logic              irq,
   input logic              busy,
   input logic [SIZE_W-1:0] progress,
   input logic [SIZE_W-1:0] height
);
   logic ctrl_write;
   assign ctrl_write = bus_sel & bus_wr & (bus_addr == ADDR_W'(OFS_CTRL));

   a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> !wr_start);
   a_r4_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |-> busy && progress == '0 && vstart);
   a_r5_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> (progress == $past(progress) ||
                                 progress == $past(progress) + 1'b1));
   a_r6_finish: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && progress >= height && !wr_start) |=> !busy);
   a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> !wr_start);
   a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
      wr_abort |-> !busy && !vstart && $past(busy));
   a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !busy && $past(busy));
   a_r11_pd_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctrl_write) |-> $stable(mem_pd));
   a_r10_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_start, wr_abort}));
endmodule

bind fwb_ctrl fwb_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .wr_start(wr_start), .wr_abort(wr_abort),
   .vstart(vstart), .mem_pd(mem_pd), .irq(irq), .busy(busy),
   .progress(progress), .height(height)
);

// File: tb/sim_fwb_ctrl.sv
`timescale 1ns/1ps
module sim_fwb_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0, line_done = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wr_start, wr_abort, vstart, mem_pd, irq;
   int          total = 0, bad = 0;
   logic [31:0] rv;
   bit          finished = 0;

   localparam logic [31:0] FIX = 32'h5440_0000;

   always #5 clk = ~clk;

   fwb_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .line_done(line_done), .wr_start(wr_start), .wr_abort(wr_abort),
      .vstart(vstart), .mem_pd(mem_pd), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a; bus_sel = 1; bus_wr = 0;
      #1 d = bus_rdata;
      bus_sel = 0;
   endtask

   task automatic line();
      @(negedge clk); line_done = 1;
      @(posedge clk); #1; line_done = 0;
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      tick();
      // R1 reset state
      rd(5'h00, rv); chk("R1 ptr", rv, 0);
      rd(5'h04, rv); chk("R1 pitch", rv, 0);
      rd(5'h08, rv); chk("R1 size", rv, 0);
      rd(5'h0C, rv); chk("R1 ctrl", rv, FIX);
      rd(5'h10, rv); chk("R1 prog", rv, 0);
      chk("R1 outs", {27'd0, wr_start, wr_abort, vstart, mem_pd, irq}, 0);

      // R2 register storage
      wr(5'h00, 32'hDEAD_BEE0); rd(5'h00, rv); chk("R2 ptr", rv, 32'hDEAD_BEE0);
      wr(5'h04, 32'h0000_1F40); rd(5'h04, rv); chk("R2 pitch", rv, 32'h0000_1F40);
      wr(5'h08, 32'h0438_0780); rd(5'h08, rv); chk("R2 size", rv, 32'h0438_0780);

      // R12 progress write ignored
      wr(5'h10, 32'h0000_FFFF); rd(5'h10, rv); chk("R12 prog ro", rv, 0);

      // R3 / R11 fixed fields and power-down
      wr(5'h0C, 32'hFFFF_BFFE);
      rd(5'h0C, rv); chk("R3 ctrl mask", rv, 32'h547F_BFFC);
      chk("R11 pd on", 32'(mem_pd), 1);
      chk("R3 no start", 32'(wr_start), 0);
      wr(5'h0C, 32'h0);
      rd(5'h0C, rv); chk("R3 ctrl clr", rv, FIX);
      chk("R11 pd off", 32'(mem_pd), 0);

      // R8 abort while idle
      wr(5'h0C, 32'h0000_4000);
      chk("R8 idle abort", {30'd0, wr_abort, irq}, 0);

      // Sweep over heights: R4 R5 R6 R9 R10
      for (int h = 0; h < 6; h++) begin
         logic ie_b, eof_b;
         logic [31:0] cw;
         ie_b  = (h % 2) == 0;
         eof_b = (h % 2) == 1;
         wr(5'h08, {16'(h), 16'd64});
         line();
         rd(5'h10, rv);
         if (h > 0) chk("R5 idle line", rv, 32'(h - 1));
         cw = 32'h1 | (32'(ie_b) << 2) | (32'(eof_b) << 15);
         wr(5'h0C, cw);
         chk("R4 wr_start", 32'(wr_start), 1);
         chk("R10 vstart start", 32'(vstart), 1);
         rd(5'h0C, rv); chk("R4 busy", rv & 32'h2, 2);
         rd(5'h10, rv); chk("R4 prog zero", rv, 0);
         for (int k = 0; k < h; k++) begin
            line();
            chk("R4 pulse end", 32'(wr_start), 0);
            rd(5'h10, rv); chk("R5 count", rv, 32'(k + 1));
            rd(5'h0C, rv); chk("R6 still busy", rv & 32'h2, 2);
         end
         tick();
         rd(5'h0C, rv); chk("R6 idle", rv & 32'h2, 0);
         rd(5'h10, rv); chk("R6 prog held", rv, 32'(h));
         chk("R9 irq", 32'(irq), 32'(ie_b));
         chk("R10 vstart eof", 32'(vstart), 32'(eof_b));
         tick();
         chk("R10 vstart one", 32'(vstart), 0);
         chk("R9 irq holds", 32'(irq), 32'(ie_b));
         wr(5'h0C, 32'h0);
         chk("R9 irq clear", 32'(irq), 0);
      end

      // R7 start while busy, then R8 abort while busy
      wr(5'h08, {16'd5, 16'd8});
      wr(5'h0C, 32'h5);
      tick();
      line();
      wr(5'h0C, 32'h5);
      chk("R7 no wr_start", 32'(wr_start), 0);
      chk("R7 no vstart", 32'(vstart), 0);
      rd(5'h10, rv); chk("R7 prog kept", rv, 1);
      line();
      wr(5'h0C, 32'h0000_4004);
      chk("R8 wr_abort", 32'(wr_abort), 1);
      chk("R8 no vstart", 32'(vstart), 0);
      chk("R9 irq abort", 32'(irq), 1);
      rd(5'h0C, rv); chk("R8 idle", rv & 32'h2, 0);
      rd(5'h10, rv); chk("R8 prog held", rv, 2);
      tick();
      chk("R8 abort one", 32'(wr_abort), 0);
      line();
      rd(5'h10, rv); chk("R5 ignore idle", rv, 2);
      wr(5'h0C, 32'h0);
      chk("R9 irq clr2", 32'(irq), 0);

      finish_run();
   end
endmodule